// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves 8-bit data between two ports, A and B, through two independent banks of storage. One bank carries values from port A towards port B and the other carries values from port B towards port A. Each direction has three active-low controls of its own: a chip enable, a latch enable and an output enable. The chip enable must be low both for the bank to take in new data and for the far port to be driven. The latch enable decides whether the bank follows its source port or keeps what it has. The output enable decides whether the far port is driven.

Storage is built as clocked sampling with the same meaning as a transparent latch. While a bank is open, meaning its chip enable and latch enable are both low, it samples its source port on every rising clock edge. At the first edge where either control is high, it stops sampling and keeps the last value it took. Data therefore reaches the far port one clock after it appears on the source port. Drive enables are combinational from the controls, so they respond in the same cycle.

Each port has an input bus, an output bus and a drive-enable flag, so a tri-state pad can be added outside the block. When a port's drive flag is low, its output bus is forced to zero. A synchronous active-low reset clears both banks and holds both drive flags low.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While rst_n is low at a rising edge, both banks clear to zero. While rst_n is low, a_drive and b_drive are low and a_out and b_out are zero.
- R2: If ab_ce_n and ab_le_n are both low at a rising edge, the A-to-B bank takes the value of a_in at that edge.
- R3: If ab_le_n is high at a rising edge, the A-to-B bank keeps its value. A change on a_in after the latch closes does not reach b_out.
- R4: If ab_ce_n is high at a rising edge, the A-to-B bank keeps its value whatever the level of ab_le_n.
- R5: b_drive is high in the same cycle exactly when rst_n, ab_ce_n and ab_oe_n are high, low and low respectively.
- R6: When a port's drive flag is high, its output bus equals its bank's contents. When the flag is low, the output bus is all zeros.
- R7: The B-to-A direction follows R2 to R6 with ba_ce_n, ba_le_n, ba_oe_n, b_in, a_out and a_drive.
- R8: The controls and source port of one direction have no effect on the other direction's bank, output bus or drive flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Data arriving on port A |
| a_out | output | 8 | Data for port A (B-to-A bank), zero when not driving |
| a_drive | output | 1 | Port A output-drive enable |
| b_in | input | 8 | Data arriving on port B |
| b_out | output | 8 | Data for port B (A-to-B bank), zero when not driving |
| b_drive | output | 1 | Port B output-drive enable |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low (low means open) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low (low means open) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Both directions can capture and drive in the same cycle, and one direction can be driving while the other captures. The sweep steps through all 64 combinations of the six control bits, each with several data patterns on both ports. As a result, captures, holds and drives of the two directions fall on the same edges in every combination. A bench model of each bank is updated only from that direction's own controls. Each port's drive flag and output bus are compared with this model just before every rising edge, so any effect of one direction on the other shows up as a mismatch.

// File: rtl/xcvr_pkg.sv
// Package xcvr_pkg
// Shared types for the bidirectional latched transceiver.
// Assumes: controls are active low; a direction is "open" when ce and le are low.
package xcvr_pkg;

    // Default data width of each bank.
    localparam int unsigned XCVR_WIDTH = 8;

    // Number of transfer directions (A-to-B, B-to-A).
    localparam int unsigned XCVR_DIRS = 2;

    // Index of each direction in the per-direction arrays.
    localparam int unsigned DIR_AB = 0;
    localparam int unsigned DIR_BA = 1;

    // Active-low control triple for one direction.
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;

endpackage

// File: rtl/xcvr_latch_bank.sv
// Module xcvr_latch_bank
// One storage bank. It samples its source bus on every edge while open
// (ce_n and le_n both low) and holds its value otherwise.
// Assumes: synchronous active-low reset clears the bank to zero.
module xcvr_latch_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             le_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] q
);

    logic open_w;

    // Bank is transparent only when chip and latch enables are both low.
    always_comb open_w = ~ce_n & ~le_n;

    // Storage update: clear on reset, sample while open, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (open_w)
            q <= src;
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !le_n) |=> (q == $past(src)));

    // R3
    hold_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_n |=> $stable(q));

    // R4
    hold_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(q));

endmodule

// File: rtl/xcvr_drive_gate.sv
// Module xcvr_drive_gate
// Output stage for one direction. It raises the drive flag when chip and
// output enables are both low and reset is released, and it presents the
// bank contents only while driving.
// Assumes: the flag feeds a tri-state pad outside this block.
module xcvr_drive_gate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    // Drive decision from the direction's own controls only.
    always_comb drive = rst_n & ~ce_n & ~oe_n;

    // Present stored data while driving, zeros otherwise.
    always_comb dout = drive ? q : '0;

endmodule

// File: rtl/xcvr_direction.sv
// Module xcvr_direction
// One complete transfer path: a storage bank followed by its output gate.
// Assumes: source and destination ports are chosen by the parent.
module xcvr_direction
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    logic [WIDTH-1:0] bank_q;

    xcvr_latch_bank #(.WIDTH(WIDTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ctrl.ce_n),
        .le_n  (ctrl.le_n),
        .src   (src),
        .q     (bank_q)
    );

    xcvr_drive_gate #(.WIDTH(WIDTH)) u_gate (
        .rst_n (rst_n),
        .ce_n  (ctrl.ce_n),
        .oe_n  (ctrl.oe_n),
        .q     (bank_q),
        .dout  (dout),
        .drive (drive)
    );

    // R6
    drive_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (dout == bank_q));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (dout == '0));

    // R5
    drive_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ce_n |-> !drive);

endmodule

// File: rtl/bidir_latch_xcvr.sv
// Module bidir_latch_xcvr
// Two-port transceiver. It has one bank from A to B and one from B to A,
// each with its own active-low chip, latch and output enables.
// Assumes: bus contention between the two drive flags is resolved outside.
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    input  logic             ab_ce_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_ce_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n
);

    dir_ctrl_t        ctrl_w  [XCVR_DIRS];
    logic [WIDTH-1:0] src_w   [XCVR_DIRS];
    logic [WIDTH-1:0] dout_w  [XCVR_DIRS];
    logic             drive_w [XCVR_DIRS];

    // Route pins into per-direction arrays.
    always_comb begin
        ctrl_w[DIR_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
        ctrl_w[DIR_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
        src_w[DIR_AB]  = a_in;
        src_w[DIR_BA]  = b_in;
    end

    for (genvar g = 0; g < XCVR_DIRS; g++) begin : g_dir
        xcvr_direction #(.WIDTH(WIDTH)) u_dir (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (ctrl_w[g]),
            .src   (src_w[g]),
            .dout  (dout_w[g]),
            .drive (drive_w[g])
        );
    end

    // Each bank's output lands on the opposite port.
    always_comb begin
        b_out   = dout_w[DIR_AB];
        b_drive = drive_w[DIR_AB];
        a_out   = dout_w[DIR_BA];
        a_drive = drive_w[DIR_BA];
    end

    // R8
    ab_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ab_ce_n) && $stable({ab_ce_n, ab_oe_n})) |-> $stable(b_out));

    // R8
    ba_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ba_ce_n) && $stable({ba_ce_n, ba_oe_n})) |-> $stable(a_out));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!a_drive && !b_drive && a_out == '0 && b_out == '0));

endmodule

// File: tb/bidir_latch_xcvr_bench.sv
module bidir_latch_xcvr_bench;

    localparam int  PERIOD = 10;
    localparam int  W      = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_drive, b_drive;
    logic         ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;

    int           compared   = 0;
    int           mismatched = 0;
    logic [W-1:0] ab_m = '0;
    logic [W-1:0] ba_m = '0;
    string        ab_tag = "R1";
    string        ba_tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W)) u_bidir_latch_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Compare both ports against the bench model of the current cycle.
    task automatic check_ports();
        logic bd, ad;
        bd = rst_n & ~ab_ce_n & ~ab_oe_n;
        ad = rst_n & ~ba_ce_n & ~ba_oe_n;
        check("R5", "b_drive", {7'b0, b_drive}, {7'b0, bd});
        check("R7", "a_drive", {7'b0, a_drive}, {7'b0, ad});
        check({"R6/", ab_tag}, "b_out", b_out, bd ? ab_m : '0);
        check({"R7/", ba_tag}, "a_out", a_out, ad ? ba_m : '0);
    endtask

    // One cycle: drive at negedge, check before the edge, update model at the edge.
    task automatic step(input logic [2:0] abc, input logic [2:0] bac,
                        input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        {ab_ce_n, ab_le_n, ab_oe_n} = abc;
        {ba_ce_n, ba_le_n, ba_oe_n} = bac;
        a_in = av;
        b_in = bv;
        #1;
        check_ports();
        @(posedge clk);
        if (!abc[2] && !abc[1]) begin ab_m = av; ab_tag = "R2"; end
        else if (abc[2])        ab_tag = "R4";
        else                    ab_tag = "R3";
        if (!bac[2] && !bac[1]) begin ba_m = bv; ba_tag = "R2"; end
        else if (bac[2])        ba_tag = "R4";
        else                    ba_tag = "R3";
    endtask

    initial begin
        #(PERIOD * 200000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        a_in = 8'hFF; b_in = 8'hAA;
        {ab_ce_n, ab_le_n, ab_oe_n} = 3'b000;
        {ba_ce_n, ba_le_n, ba_oe_n} = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: in reset, even with all enables low, nothing drives.
        check("R1", "b_drive", {7'b0, b_drive}, 8'h00);
        check("R1", "a_drive", {7'b0, a_drive}, 8'h00);
        check("R1", "b_out", b_out, 8'h00);
        check("R1", "a_out", a_out, 8'h00);
        {ab_ce_n, ab_le_n, ab_oe_n} = 3'b111;
        {ba_ce_n, ba_le_n, ba_oe_n} = 3'b111;
        rst_n = 1'b1;
        // R1: after release, drive to show the cleared banks.
        step(3'b011, 3'b011, 8'h12, 8'h34);
        step(3'b010, 3'b010, 8'h56, 8'h78);

        // R3: capture, close, then change a_in; b_out keeps captured value.
        step(3'b000, 3'b000, 8'h5A, 8'hA5);
        step(3'b010, 3'b010, 8'hC3, 8'h3C);
        step(3'b010, 3'b010, 8'h0F, 8'hF0);
        check("R3", "b_out explicit", b_out, 8'h5A);
        check("R7", "a_out explicit", a_out, 8'hA5);

        // R4: ce high with le low holds; then drive to observe.
        step(3'b100, 3'b100, 8'h99, 8'h66);
        step(3'b010, 3'b010, 8'h11, 8'h22);
        check("R4", "b_out after ce high", b_out, 8'h5A);

        // R8: toggle A-to-B heavily while B-to-A is driving and closed.
        for (int k = 0; k < 4; k++)
            step(3'(k), 3'b010, 8'(k * 29 + 3), 8'hE7);
        check("R8", "a_out isolated", a_out, 8'hA5);

        // Sweep all control combinations with several data patterns.
        for (int c = 0; c < 64; c++)
            for (int k = 0; k < 4; k++)
                step(c[5:3], c[2:0], 8'(c * 37 + k * 91), 8'(~(c * 37 + k * 91) ^ k));

        step(3'b010, 3'b010, 8'h00, 8'h00);
        finish_run();
    end

endmodule